// File: doc/BRIEF.md
# Multi-Baseline Two-Bit Lag Correlator

This block accepts six streams of 2-bit quantized samples, one sample per stream on every clock, and forms the cross-correlation of every distinct pair of streams (15 baselines) over a parameterized number of lags. Each correlation channel multiplies a sample of the first stream by a delayed sample of the second. It looks the product up from the 2-bit codes and adds it to a saturating signed integrator.

A period timer closes each integration after a fixed number of clocks. On that edge every integrator is copied into a dump shift register and cleared. The snapshot then leaves on a single serial line at one bit per four core clocks, while the next integration runs. If the previous frame is still being shifted out when a period closes, the new snapshot is discarded and an overrun pulse is raised.

Top module: `lag_correlator`

## Requirements
- R1: Stream i occupies bits [2i+1:2i] of `samples_i`. Code bit 1 is the sign (1 = negative) and bit 0 the magnitude (1 = 3, 0 = 1): 00=+1, 01=+3, 10=-1, 11=-3. Channel (a,b,k) adds the product of the newest registered sample of stream a and the sample of stream b registered k clocks earlier.
- R2: Channels are numbered c = p*LAGS + k. Pair index p runs over a<b in order (0,1),(0,2)..(0,5),(1,2)..(4,5). The frame sends channel 0 first, and each ACC_W-bit two's-complement field goes MSB first.
- R3: An integrator of ACC_W bits clamps at +(2^(ACC_W-1)-1) and -(2^(ACC_W-1)) rather than wrapping.
- R4: A period closes on every PERIOD-th clock edge after reset. The snapshot includes the product added at that edge, and the integrator restarts from zero, so every period holds exactly PERIOD products.
- R5: A sample present at an edge is registered there and first contributes at the following edge. Before any sample arrives, the delay stages hold code 00 (+1).
- R6: After an accepted close, `ser_active_o` is high for 4*15*LAGS*ACC_W clocks. Each bit is held for 4 clocks, the first one right after the closing edge, and `ser_frame_o` is high only while the first bit is shown.
- R7: A period that closes while a frame is active raises `overrun_o` for exactly one clock and drops that snapshot. The frame in progress continues unchanged.
- R8: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| samples_i | input | 2*NIN | Packed 2-bit codes, one per stream |
| ser_data_o | output | 1 | Serial dump data, MSB first |
| ser_frame_o | output | 1 | High while the first bit of a frame is shown |
| ser_active_o | output | 1 | High while a frame is being shifted out |
| overrun_o | output | 1 | One-clock pulse when a snapshot is dropped |

## Verification
The bench builds the block with LAGS=4, ACC_W=12 and PERIOD=2000. One frame then takes 2880 clocks, longer than a period, so every second close collides with a frame in progress. Overruns and uninterrupted frames are both exercised within a few thousand clocks. The 12-bit integrators clamp after about 230 full-scale products, so a period of constant same-sign and opposite-sign inputs drives every channel to one of its limits.

// File: rtl/corr_pkg.sv
package corr_pkg;
  // sign/magnitude 2-bit code product: {sign, mag}, mag 1 -> 3
  function automatic logic signed [4:0] code_prod(input logic [1:0] a, input logic [1:0] b);
    logic [3:0] mag;
    case ({a[0], b[0]})
      2'b00:   mag = 4'd1;
      2'b11:   mag = 4'd9;
      default: mag = 4'd3;
    endcase
    return (a[1] ^ b[1]) ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  endfunction

  function automatic int pair_index(input int a, input int b, input int n);
    return a * (2 * n - a - 1) / 2 + b - a - 1;
  endfunction
endpackage

// File: rtl/corr_period_timer.sv
module corr_period_timer #(
  parameter int PERIOD = 7812500
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic dump_o
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q;

  assign dump_o = (cnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (dump_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  if (PERIOD > 1) begin : g_chk
    // R4: one close per period
    a_r4_single_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dump_o |=> !dump_o);
  end
endmodule

// File: rtl/corr_lag_channel.sv
module corr_lag_channel
  import corr_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       a_i,
  input  logic [1:0]       b_i,
  input  logic             clear_i,
  output logic [ACC_W-1:0] sum_o
);
  localparam int EW = ACC_W + 1;
  localparam logic signed [ACC_W-1:0] AMAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] AMIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc_q, nxt;
  logic signed [4:0]       prod;
  logic signed [EW-1:0]    ext;

  always_comb begin
    prod = code_prod(a_i, b_i);
    ext  = EW'(acc_q) + EW'(prod);
    if (ext > EW'(AMAX))      nxt = AMAX;
    else if (ext < EW'(AMIN)) nxt = AMIN;
    else                      nxt = ext[ACC_W-1:0];
  end

  assign sum_o = nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else              acc_q <= nxt;
  end

  a_r3_clamp_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q == AMAX && prod > 0 && !clear_i) |=> acc_q == AMAX);
  a_r3_clamp_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q == AMIN && prod < 0 && !clear_i) |=> acc_q == AMIN);
  a_r4_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> acc_q == '0);
endmodule

// File: rtl/corr_serializer.sv
module corr_serializer #(
  parameter int TOTAL = 1920
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dump_i,
  input  logic [TOTAL-1:0] snap_i,
  output logic             data_o,
  output logic             frame_o,
  output logic             active_o,
  output logic             overrun_o
);
  localparam int BW = (TOTAL > 1) ? $clog2(TOTAL) : 1;

  logic [TOTAL-1:0] sh_q;
  logic [BW-1:0]    bit_q;
  logic [1:0]       ph_q;
  logic             act_q, ovr_q;
  logic             load;

  assign load      = dump_i && !act_q;
  assign data_o    = act_q && sh_q[TOTAL-1];
  assign frame_o   = act_q && (bit_q == '0);
  assign active_o  = act_q;
  assign overrun_o = ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      bit_q <= '0;
      ph_q  <= '0;
      act_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      ovr_q <= dump_i && act_q;
      if (load) begin
        sh_q  <= snap_i;
        bit_q <= '0;
        ph_q  <= '0;
        act_q <= 1'b1;
      end else if (act_q) begin
        ph_q <= ph_q + 1'b1;
        if (ph_q == 2'd3) begin
          sh_q <= sh_q << 1;
          if (bit_q == BW'(TOTAL - 1)) act_q <= 1'b0;
          else                         bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  a_r6_frame_inside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> active_o);
  a_r6_bit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && ph_q != 2'd3 && !dump_i) |=> $stable(data_o));
  a_r6_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dump_i && !act_q) |=> (frame_o && active_o && !overrun_o));
  a_r7_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dump_i && act_q) |=> (overrun_o && active_o));
endmodule

// File: rtl/lag_correlator.sv
module lag_correlator
  import corr_pkg::*;
#(
  parameter int NIN    = 6,
  parameter int LAGS   = 8,
  parameter int ACC_W  = 16,
  parameter int PERIOD = 7812500
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2*NIN-1:0] samples_i,
  output logic            ser_data_o,
  output logic            ser_frame_o,
  output logic            ser_active_o,
  output logic            overrun_o
);
  localparam int NBL   = NIN * (NIN - 1) / 2;
  localparam int NCH   = NBL * LAGS;
  localparam int TOTAL = NCH * ACC_W;

  logic [1:0]       dly_q [NIN][LAGS];
  logic [TOTAL-1:0] snap;
  logic             dump;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NIN; i++)
        for (int k = 0; k < LAGS; k++) dly_q[i][k] <= 2'b00;
    end else begin
      for (int i = 0; i < NIN; i++) begin
        dly_q[i][0] <= samples_i[2*i +: 2];
        for (int k = 1; k < LAGS; k++) dly_q[i][k] <= dly_q[i][k-1];
      end
    end
  end

  corr_period_timer #(.PERIOD(PERIOD)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .dump_o(dump)
  );

  for (genvar ga = 0; ga < NIN; ga++) begin : g_a
    for (genvar gb = ga + 1; gb < NIN; gb++) begin : g_b
      for (genvar gk = 0; gk < LAGS; gk++) begin : g_k
        localparam int CH = pair_index(ga, gb, NIN) * LAGS + gk;
        logic [ACC_W-1:0] sum;
        corr_lag_channel #(.ACC_W(ACC_W)) u_ch (
          .clk_i  (clk_i),
          .rst_ni (rst_ni),
          .a_i    (dly_q[ga][0]),
          .b_i    (dly_q[gb][gk]),
          .clear_i(dump),
          .sum_o  (sum)
        );
        // channel 0 in the top bits, so it leaves first
        assign snap[(NCH-CH)*ACC_W-1 -: ACC_W] = sum;
      end
    end
  end

  corr_serializer #(.TOTAL(TOTAL)) u_ser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dump_i   (dump),
    .snap_i   (snap),
    .data_o   (ser_data_o),
    .frame_o  (ser_frame_o),
    .active_o (ser_active_o),
    .overrun_o(overrun_o)
  );

  // R5: delay stage k of stream 0 follows stage k-1 by one clock
  if (LAGS > 1) begin : g_dchk
    a_r5_delay_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$isunknown(dly_q[0][0]) |=> dly_q[0][1] == $past(dly_q[0][0]));
  end
endmodule

// File: tb/tb_lag_correlator.sv
module tb_lag_correlator;
  localparam int CLK_PERIOD = 10;
  localparam int NIN    = 6;
  localparam int LAGS   = 4;
  localparam int ACC_W  = 12;
  localparam int PERIOD = 2000;
  localparam int NBL    = 15;
  localparam int NCH    = NBL * LAGS;
  localparam int TOTAL  = NCH * ACC_W;
  localparam int NEDGE  = 9000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2*NIN-1:0] samples = '0;
  logic             ser_data, ser_frame, ser_active, overrun;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  int hist [NIN][LAGS];
  int acc  [NCH];
  int snap [NCH];
  int pa [NBL], pb [NBL];
  bit m_act = 0;
  int m_start = 0;
  int frame_no = 0;
  bit exp_ovr;

  always #(CLK_PERIOD/2) clk = ~clk;

  lag_correlator #(.NIN(NIN), .LAGS(LAGS), .ACC_W(ACC_W), .PERIOD(PERIOD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .samples_i(samples),
    .ser_data_o(ser_data), .ser_frame_o(ser_frame),
    .ser_active_o(ser_active), .overrun_o(overrun)
  );

  function automatic int code_val(input int c);
    int m = (c & 1) ? 3 : 1;
    return (c & 2) ? -m : m;
  endfunction

  function automatic int sat(input int v);
    int hi = (1 << (ACC_W - 1)) - 1;
    int lo = -(1 << (ACC_W - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge(input int n);
    for (int p = 0; p < NBL; p++)
      for (int k = 0; k < LAGS; k++)
        acc[p*LAGS+k] = sat(acc[p*LAGS+k] + code_val(hist[pa[p]][0]) * code_val(hist[pb[p]][k]));
    exp_ovr = 0;
    if (n % PERIOD == 0) begin
      if (m_act && (n - m_start) <= 4*TOTAL) exp_ovr = 1;
      else begin
        for (int c = 0; c < NCH; c++) snap[c] = acc[c];
        m_act = 1;
        m_start = n;
        frame_no++;
      end
      for (int c = 0; c < NCH; c++) acc[c] = 0;
    end
    if (m_act && (n - m_start) >= 4*TOTAL) m_act = 0;
    for (int i = 0; i < NIN; i++) begin
      for (int k = LAGS - 1; k > 0; k--) hist[i][k] = hist[i][k-1];
      hist[i][0] = int'(samples[2*i +: 2]);
    end
  endtask

  task automatic check_outputs(input int n);
    int d, j, c, b, eb;
    string tag;
    check(overrun == exp_ovr, "R7 overrun pulse", int'(overrun), int'(exp_ovr));
    if (m_act) begin
      d  = n - m_start;
      j  = d / 4;
      c  = j / ACC_W;
      b  = ACC_W - 1 - (j % ACC_W);
      eb = (snap[c] >>> b) & 1;
      if (frame_no >= 2)  tag = "R3 clamped frame bit";
      else if (n > 2*PERIOD) tag = "R7 frame continues past dropped close";
      else tag = "R1 R2 R4 R5 frame bit";
      check(ser_data == eb[0], tag, int'(ser_data), eb);
      check(ser_frame == (j == 0), "R6 frame marker", int'(ser_frame), int'(j == 0));
      check(ser_active == 1'b1, "R6 active during frame", int'(ser_active), 1);
    end else begin
      check(ser_active == 1'b0, "R6 idle after frame", int'(ser_active), 0);
      check(ser_frame == 1'b0, "R6 no marker when idle", int'(ser_frame), 0);
    end
  endtask

  initial begin
    int p, s;
    p = 0;
    for (int a = 0; a < NIN; a++)
      for (int b = a + 1; b < NIN; b++) begin
        pa[p] = a; pb[p] = b; p++;
      end
    for (int i = 0; i < NIN; i++)
      for (int k = 0; k < LAGS; k++) hist[i][k] = 0;
    for (int c = 0; c < NCH; c++) begin acc[c] = 0; snap[c] = 0; end
    s = $urandom(32'd4711);

    repeat (3) @(negedge clk);
    samples = '1;
    @(negedge clk);
    // R8: outputs held low in reset
    check(ser_data == 0, "R8 reset data", int'(ser_data), 0);
    check(ser_frame == 0, "R8 reset frame", int'(ser_frame), 0);
    check(ser_active == 0, "R8 reset active", int'(ser_active), 0);
    check(overrun == 0, "R8 reset overrun", int'(overrun), 0);
    rst_n = 1'b1;

    for (int n = 1; n <= NEDGE; n++) begin
      if (n > 2*PERIOD && n <= 3*PERIOD) begin
        // streams 0..2 at +3, streams 3..5 at -3
        for (int i = 0; i < NIN; i++) samples[2*i +: 2] = (i < 3) ? 2'b01 : 2'b11;
      end else begin
        samples = 12'($urandom);
      end
      @(posedge clk);
      model_edge(n);
      @(negedge clk);
      if (n == PERIOD - 1)
        check(ser_active == 0, "R4 no close before period end", int'(ser_active), 0);
      if (n == PERIOD)
        check(ser_frame == 1, "R4 close on period edge", int'(ser_frame), 1);
      check_outputs(n);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule